// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

This block is a synthesizable behavioural model of a clocked static RAM with 32-bit words, four 8-bit byte lanes and a two-stage read pipeline. Address, write data and the command pins are all sampled on the rising clock edge. An access begins when one of two address strobes is low while all three chip enables are active. One strobe is for a processor and the other for a cache controller. A 2-bit counter then produces the next three addresses of a four-word group. The burst steps in linear or interleaved order, chosen by a static mode pin.

Writes take place at the edge that samples them. A global write stores the whole word, and a byte-write enable stores the lanes picked by four byte selects. A sleep input stops all activity and keeps the array contents. When it is released, a fixed number of clock edges is ignored before commands are accepted again. Output enable gates the read data driver directly. Depth is set by an address-width parameter and is kept small.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle with `adsp_n` or `adsc_n` low and all chip enables active (`ce1_n`=0, `ce2`=1, `ce3_n`=0) starts a burst at `addr` with count 0. A start by `adsp_n` is always a read, even if write pins are asserted. A start by `adsc_n` alone is a write when write is qualified and a read otherwise.
- R2: Read data for an address sampled at edge t is driven on `q`, with `q_drv`=1, after edge t+1 and until edge t+2. A write cycle gives `q_drv`=0 one edge later.
- R3: With a burst active and no strobe low, `adv_n`=0 adds one to the 2-bit count. The low two address bits are start+count modulo 4 when `burst_mode`=0, and start XOR count when `burst_mode`=1. Address bits above bit 1 never change inside a burst.
- R4: With a burst active, no strobe low and `adv_n`=1, the same address is accessed again.
- R5: With `gw_n`=1 and `bwe_n`=0, `bw_n[i]`=0 writes lane i (bits 8i+7..8i). With `bwe_n`=1 the `bw_n` pins have no effect, and the cycle is a read.
- R6: `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` are.
- R7: A strobe low while any chip enable is inactive ends the burst. It writes nothing, and the following idle cycles produce no read data.
- R8: While `sleep`=1, and for the first three edges after it falls, every command is ignored and `q_drv`=0. Array contents are kept. The fourth edge accepts commands.
- R9: `oe_n`=1 forces `q_drv`=0 and `q`=0 at once, without a clock edge. Data returns when `oe_n` goes low again.
- R10: After reset no burst is active and `q_drv`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | ADDR_W | Word address sampled on a start |
| adsp_n | input | 1 | Processor address strobe, active low, read start |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Byte lane selects, active low, bit i is lane i |
| wdata | input | 32 | Write data |
| burst_mode | input | 1 | 0 linear, 1 interleaved |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| q | output | 32 | Read data, zero when not driven |
| q_drv | output | 1 | High while `q` drives the data bus |

## Verification
The assertions assume a clean clock and a `burst_mode` pin that changes only between edges. They also assume that a strobe's meaning is judged only when `sleep` is low and the wake-up count has run out, since commands are dropped otherwise. The stimulus keeps to this by driving every input at the falling edge, holding the chip enables active except in the deselect test, and changing `burst_mode` only from one vector to the next. Expected read data is tracked one edge behind the issuing vector, which matches the two-register read path.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 adsp_n,
  input  logic                 adsc_n,
  input  logic                 adv_n,
  input  logic                 ce1_n,
  input  logic                 ce2,
  input  logic                 ce3_n,
  input  logic                 gw_n,
  input  logic                 bwe_n,
  input  logic [LANES-1:0]     bw_n,
  input  logic [8*LANES-1:0]   wdata,
  input  logic                 burst_mode,
  input  logic                 sleep,
  input  logic                 oe_n,
  output logic [8*LANES-1:0]   q,
  output logic                 q_drv
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DW     = 8 * LANES;
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);

  logic [DW-1:0]     mem [DEPTH];
  logic              act, rd_v, q_v;
  logic [ADDR_W-1:0] base, rd_addr;
  logic [1:0]        cnt;
  logic [DW-1:0]     q_r;
  logic [WAKE_W-1:0] wake_cnt;

  wire ready  = !sleep && (wake_cnt == '0);
  wire cs     = !ce1_n && ce2 && !ce3_n;
  wire strobe = !adsp_n || !adsc_n;
  wire start  = ready && strobe && cs;
  wire desel  = ready && strobe && !cs;
  wire cont   = ready && !strobe && act;
  wire step   = cont && !adv_n;
  wire access = start || cont;

  wire [1:0]        cnt_nx  = start ? 2'd0 : (step ? cnt + 2'd1 : cnt);
  wire [ADDR_W-1:0] base_nx = start ? addr : base;
  wire [1:0]        low     = burst_mode ? (base_nx[1:0] ^ cnt_nx) : (base_nx[1:0] + cnt_nx);
  wire [ADDR_W-1:0] cur     = {base_nx[ADDR_W-1:2], low};

  wire [LANES-1:0] lane_en = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);
  wire do_wr = access && !(start && !adsp_n) && (lane_en != '0);
  wire do_rd = access && !do_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (do_wr && lane_en[g]) mem[cur][8*g +: 8] <= wdata[8*g +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      base     <= '0;
      cnt      <= '0;
      rd_v     <= 1'b0;
      rd_addr  <= '0;
      q_v      <= 1'b0;
      wake_cnt <= '0;
    end else if (sleep) begin
      act      <= 1'b0;
      rd_v     <= 1'b0;
      q_v      <= 1'b0;
      wake_cnt <= WAKE_W'(WAKE_CYC);
    end else begin
      q_v <= rd_v;
      if (wake_cnt != '0) wake_cnt <= wake_cnt - 1'b1;
      if (ready) begin
        base    <= base_nx;
        cnt     <= cnt_nx;
        rd_addr <= cur;
        rd_v    <= do_rd;
        if (start)      act <= 1'b1;
        else if (desel) act <= 1'b0;
      end else begin
        rd_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) q_r <= mem[rd_addr];

  assign q_drv = !oe_n && q_v && !sleep;
  assign q     = q_drv ? q_r : '0;

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (act && cnt == 2'd0 && base == $past(addr)));
  assert_adsp_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !adsp_n && !sleep) |=> rd_v);
  assert_pipe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    q_v |-> $past(rd_v));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !sleep) |=> cnt == $past(cnt) + 2'd1);
  assert_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !sleep) |=> base == $past(base));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && adv_n && !sleep) |=> $stable(cnt));
  assert_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (desel && !sleep) |=> !act);
  assert_wake_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> wake_cnt == WAKE_W'(WAKE_CYC));
  assert_wake_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && wake_cnt != '0) |=> (sleep || wake_cnt == $past(wake_cnt) - 1'b1));
  assert_idle_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !rd_v);
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int CLK_P = 10;
  localparam int NV = 21;

  typedef struct packed {
    logic        adsp_n, adsc_n, adv_n, gw_n, bwe_n;
    logic [3:0]  bw_n;
    logic        mode;
    logic [5:0]  addr;
    logic [31:0] wd;
    logic        drv;
    logic [31:0] q;
  } vec_t;

  // fields: adsp_n adsc_n adv_n gw_n bwe_n bw_n mode addr wd | expected drv q after the edge
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,6'h10,32'hA0A0A0A0,1'b0,32'h0},        // R1 adsc write start
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,6'h00,32'hA1A1A1A1,1'b0,32'h0},        // R3
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,6'h00,32'hA2A2A2A2,1'b0,32'h0},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,6'h00,32'hA3A3A3A3,1'b0,32'h0},
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b0,6'h00,32'hA4A5A6A7,1'b0,32'h0},        // R3 wrap to 0x10
    '{1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,6'h12,32'hDEADBEEF,1'b0,32'h0},        // R1 adsp read
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA2A2A2A2},        // R2
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA3A3A3A3},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA4A5A6A7},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA1A1A1A1},        // R4
    '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,6'h13,32'h0,1'b1,32'hA1A1A1A1},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,6'h00,32'h0,1'b1,32'hA3A3A3A3},        // R3 interleave
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,6'h00,32'h0,1'b1,32'hA2A2A2A2},
    '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,6'h00,32'h0,1'b1,32'hA1A1A1A1},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,4'hA,1'b0,6'h10,32'h11223344,1'b1,32'hA4A5A6A7}, // R5 lanes 0,2
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,6'h10,32'h0,1'b0,32'h0},
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'h0,1'b0,6'h10,32'h77777777,1'b1,32'hA422A644}, // R5 bwe_n high
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hA422A644},
    '{1'b1,1'b1,1'b1,1'b0,1'b0,4'hF,1'b0,6'h00,32'hC0C1C2C3,1'b1,32'hA422A644}, // R6
    '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,6'h10,32'h0,1'b0,32'h0},
    '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b0,6'h00,32'h0,1'b1,32'hC0C1C2C3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic [31:0] wdata = '0;
  logic burst_mode = 1'b0, sleep = 1'b0, oe_n = 1'b0;
  logic [31:0] q;
  logic q_drv;
  int total = 0, bad = 0;

  sync_burst_sram i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .wdata(wdata), .burst_mode(burst_mode),
    .sleep(sleep), .oe_n(oe_n), .q(q), .q_drv(q_drv)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic exp_drv, logic [31:0] exp_q);
    total++;
    if (q_drv !== exp_drv || (exp_drv && q !== exp_q) || (!exp_drv && q !== 32'h0)) begin
      bad++;
      $display("FAIL %s: drv=%b q=%h expected drv=%b q=%h", req, q_drv, q, exp_drv,
               exp_drv ? exp_q : 32'h0);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cyc(logic p, logic c, logic a, logic g, logic be, logic [3:0] b,
                     logic [5:0] ad, logic [31:0] d);
    adsp_n = p; adsc_n = c; adv_n = a; gw_n = g; bwe_n = be; bw_n = b;
    addr = ad; wdata = d;
    step();
  endtask

  function automatic string req_of(int k);
    case (k)
      0, 5, 10: return "R1";
      1, 2, 3, 4, 11, 12, 13: return "R3";
      9: return "R4";
      14, 15, 16, 17: return "R5";
      18: return "R6";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog: drv=%b q=%h expected completion", q_drv, q);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 in reset", 1'b0, 32'h0);
    rst_n = 1'b1;
    step();
    check("R10 after reset", 1'b0, 32'h0);

    for (int k = 0; k < NV; k++) begin
      adsp_n = VEC[k].adsp_n; adsc_n = VEC[k].adsc_n; adv_n = VEC[k].adv_n;
      gw_n = VEC[k].gw_n; bwe_n = VEC[k].bwe_n; bw_n = VEC[k].bw_n;
      burst_mode = VEC[k].mode; addr = VEC[k].addr; wdata = VEC[k].wd;
      step();
      check($sformatf("%s vec %0d", req_of(k), k), VEC[k].drv, VEC[k].q);
    end

    // R7: deselect during an active burst
    ce2 = 1'b0;
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h10, 32'hEEEEEEEE);
    ce2 = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 6'h00, 32'h0);
    check("R7 no data after deselect", 1'b0, 32'h0);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, 32'h0);
    check("R7 still idle", 1'b0, 32'h0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h10, 32'h0);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, 32'h0);
    check("R7 deselect wrote nothing", 1'b1, 32'hC0C1C2C3);

    // R9: asynchronous output enable
    oe_n = 1'b1; #1;
    check("R9 oe high", 1'b0, 32'h0);
    oe_n = 1'b0; #1;
    check("R9 oe low", 1'b1, 32'hC0C1C2C3);

    // R8: sleep and wake-up
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h20, 32'h55550000);
    sleep = 1'b1; #1;
    check("R8 sleep blocks drive", 1'b0, 32'h0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h20, 32'h99999999);
    check("R8 asleep", 1'b0, 32'h0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h10, 32'h0);
    check("R8 asleep read", 1'b0, 32'h0);
    sleep = 1'b0;
    for (int w = 0; w < 3; w++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h20, 32'hBAD00000 + w);
      check($sformatf("R8 waking edge %0d", w), 1'b0, 32'h0);
    end
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 6'h21, 32'h66666666);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h20, 32'h0);
    check("R8 after wake write cycle", 1'b0, 32'h0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h21, 32'h0);
    check("R8 commands ignored while waking", 1'b1, 32'h55550000);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h10, 32'h0);
    check("R8 fourth edge accepted", 1'b1, 32'h66666666);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 6'h00, 32'h0);
    check("R8 contents kept", 1'b1, 32'hC0C1C2C3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule